// File: doc/BRIEF.md
# Predecoded Row Decoder with Wordline Mask

This block converts a 6-bit row address into the wordline enables of a memory array with 64 rows of 32 cells each. No more than one wordline is ever high. The address is captured into a register on a clock edge when a load strobe is present. It then passes through two decode stages. The first stage cuts the address into three 2-bit slices and expands each slice into four one-hot select lines, which gives 12 lines in total. The second stage gives every row a 3-input AND that takes one select line from each slice.

A final gating stage ANDs every row with a registered wordline-enable. The array controller drops this enable while the bitlines precharge, and all wordlines then stay low whatever address is held. The enable is sampled on the same clock edge as the address, so the wordline vector only changes at clock edges. After reset no row can rise until an address has been loaded at least once.

Top module: `wordlineDecoder`

## Requirements
- R1: While reset is active, and after reset until the first clock edge with `addrStrobe` high, `wordLines` is all zeros even when `wlEnable` is high.
- R2: At a rising clock edge with `addrStrobe` high, `addrIn` is captured. From that edge on, `wordLines` reflects the new address.
- R3: `addrIn` has no effect on `wordLines` at an edge where `addrStrobe` is low. The previously selected row stays asserted.
- R4: Address bits [1:0], [3:2] and [5:4] are predecoded as separate groups. Row r is high only when group k selects line (r >> 2k) & 3 for all three groups, so row r matches address value r.
- R5: At most one bit of `wordLines` is high in any cycle.
- R6: `wlEnable` is sampled at each rising edge. If it was low at the last edge, `wordLines` is all zeros whatever the stored address. A strobe during that time still loads the address.
- R7: When `wlEnable` is sampled high again, the row of the stored address returns without a new strobe.
- R8: Loading every address from 0 to 63 with the mask open asserts exactly the matching single row each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 6 | Row address to be loaded |
| addrStrobe | input | 1 | Loads `addrIn` at the next rising edge |
| wlEnable | input | 1 | Wordline enable; low keeps every wordline off (precharge) |
| wordLines | output | 64 | One-hot-or-zero row enables |

## Verification
A corrupted address register or predecode line shows up at the ports in the cycle right after the edge that loaded it. Either the wrong bit of `wordLines` rises or two bits rise together. Both are caught by comparing the whole vector with a model computed from the address, and by a population count taken every cycle. A mask register stuck open or stuck shut, or a stored address lost while masked, becomes visible one edge after `wlEnable` changes. The bench therefore checks the cycle just after each enable transition.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  // Strobes handed from the control module to the datapath
  typedef struct packed {
    logic loadAddr;  // capture the address on this edge
    logic gateOpen;  // wordlines may be driven
  } rowCtrl_t;
endpackage

// File: rtl/rowdecPredec.sv
// Expands one address slice into one-hot select lines.
module rowdecPredec #(
  parameter int GROUP_W = 2,
  localparam int LINES = 1 << GROUP_W
) (
  input  logic [GROUP_W-1:0] sel,
  output logic [LINES-1:0]   lines
);
  for (genvar i = 0; i < LINES; i++) begin : gLine
    localparam logic [GROUP_W-1:0] CODE = GROUP_W'(i);
    assign lines[i] = (sel == CODE);
  end
endmodule

// File: rtl/rowdecCtrl.sv
// Control: tracks whether an address was ever loaded and registers the mask.
module rowdecCtrl
  import rowdec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     addrStrobe,
  input  logic     wlEnable,
  output rowCtrl_t ctrl
);
  logic armed;
  logic maskOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      maskOpen <= 1'b0;
    end else begin
      if (addrStrobe) armed <= 1'b1;
      maskOpen <= wlEnable;
    end
  end

  assign ctrl.loadAddr = addrStrobe;
  assign ctrl.gateOpen = armed & maskOpen;
endmodule

// File: rtl/rowdecPath.sv
// Datapath: address register, slice predecode, per-row 3-input AND, mask.
module rowdecPath
  import rowdec_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int GROUP_W = 2,
  localparam int ROWS       = 1 << ADDR_W,
  localparam int NUM_GROUPS = ADDR_W / GROUP_W,
  localparam int LINES      = 1 << GROUP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  rowCtrl_t          ctrl,
  output logic [ROWS-1:0]   wordLines
);
  logic [ADDR_W-1:0] addrReg;
  logic [NUM_GROUPS-1:0][LINES-1:0] preLines;
  logic [ROWS-1:0] rowHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrReg <= '0;
    else if (ctrl.loadAddr) addrReg <= addrIn;
  end

  // Stage one: one predecoder per address slice
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gPre
    rowdecPredec #(.GROUP_W(GROUP_W)) uPre (
      .sel  (addrReg[g*GROUP_W +: GROUP_W]),
      .lines(preLines[g])
    );
  end

  // Stage two: each row ANDs one line from every slice
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic [NUM_GROUPS-1:0] picks;
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : gPick
      localparam int SEL = (r >> (g*GROUP_W)) & (LINES-1);
      assign picks[g] = preLines[g][SEL];
    end
    assign rowHit[r] = &picks;
  end

  // Mask stage: every wordline gated by the enable
  for (genvar r = 0; r < ROWS; r++) begin : gMask
    assign wordLines[r] = rowHit[r] & ctrl.gateOpen;
  end
endmodule

// File: rtl/wordlineDecoder.sv
module wordlineDecoder
  import rowdec_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int GROUP_W = 2,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrStrobe,
  input  logic              wlEnable,
  output logic [ROWS-1:0]   wordLines
);
  rowCtrl_t ctrl;

  rowdecCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrobe(addrStrobe),
    .wlEnable  (wlEnable),
    .ctrl      (ctrl)
  );

  rowdecPath #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .ctrl     (ctrl),
    .wordLines(wordLines)
  );
endmodule

// File: rtl/wordlineDecoderChk.sv
module wordlineDecoderChk #(
  parameter int ADDR_W = 6,
  localparam int ROWS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              addrStrobe,
  input logic              wlEnable,
  input logic [ROWS-1:0]   wordLines
);
  logic seenStrobe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seenStrobe <= 1'b0;
    else if (addrStrobe) seenStrobe <= 1'b1;
  end

  // R1
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rstN)
    !seenStrobe |-> wordLines == '0);

  // R5
  a_r5_at_most_one: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wordLines));

  // R6
  a_r6_mask_closed: assert property (@(posedge clk) disable iff (!rstN)
    (seenStrobe && !wlEnable) |=> wordLines == '0);

  // R2 / R4
  a_r2_row_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && wlEnable) |=> wordLines[$past(addrIn)]);

  // R3
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStrobe && wordLines != '0 && wlEnable) |=> wordLines == $past(wordLines));
endmodule

bind wordlineDecoder wordlineDecoderChk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .addrIn    (addrIn),
  .addrStrobe(addrStrobe),
  .wlEnable  (wlEnable),
  .wordLines (wordLines)
);

// File: tb/tb_wordlineDecoder.sv
module tb_wordlineDecoder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int ROWS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic addrStrobe = 1'b0;
  logic wlEnable = 1'b0;
  logic [ROWS-1:0] wordLines;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordlineDecoder dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .addrStrobe(addrStrobe), .wlEnable(wlEnable), .wordLines(wordLines)
  );

  function automatic logic [ROWS-1:0] rowOf(input int a);
    logic [ROWS-1:0] v;
    v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  task automatic checkVec(input string req, input logic [ROWS-1:0] exp);
    compared++;
    if (wordLines !== exp) begin
      mismatched++;
      $display("FAIL %s: wordLines=%h expected=%h", req, wordLines, exp);
    end
  endtask

  // Drive after a falling edge, sample just after the next rising edge
  task automatic step(input int a, input bit strobe, input bit en);
    @(negedge clk);
    addrIn = ADDR_W'(a);
    addrStrobe = strobe;
    wlEnable = en;
    @(posedge clk);
    #1;
  endtask

  // R5 monitor: population count on every cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      compared++;
      if ($countones(wordLines) > 1) begin
        mismatched++;
        $display("FAIL R5: ones=%0d expected<=1", $countones(wordLines));
      end
    end
  end

  task automatic testReset();
    addrIn = 6'd5; wlEnable = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkVec("R1 in reset", '0);
    @(negedge clk) rstN = 1'b1;
    step(9, 0, 1);
    checkVec("R1 unloaded", '0);
    step(12, 0, 1);
    checkVec("R1 unloaded again", '0);
  endtask

  task automatic testSweep();
    for (int a = 0; a < ROWS; a++) begin
      step(a, 1, 1);
      checkVec("R8/R4/R2 sweep", rowOf(a));
    end
  endtask

  task automatic testHold();
    step(17, 1, 1);
    checkVec("R2 load 17", rowOf(17));
    step(40, 0, 1);
    checkVec("R3 ignore addr 40", rowOf(17));
    step(63, 0, 1);
    checkVec("R3 ignore addr 63", rowOf(17));
  endtask

  task automatic testMask();
    step(40, 0, 0);
    checkVec("R6 mask closed", '0);
    step(3, 1, 0);
    checkVec("R6 load while masked", '0);
    step(22, 0, 1);
    checkVec("R7 reopen shows row 3", rowOf(3));
    step(63, 1, 1);
    checkVec("R4 top row", rowOf(63));
    step(0, 1, 0);
    checkVec("R6 masked with load 0", '0);
    step(0, 0, 1);
    checkVec("R7 reopen row 0", rowOf(0));
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    testReset();
    testSweep();
    testHold();
    testMask();
    repeat (2) @(posedge clk);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finishRun();
  end
endmodule